// File: doc/BRIEF.md
# Time-Multiplexed Configuration Bus Capture

This block sits beside a PCIe endpoint and listens to a configuration-status bus. That bus carries a subset of the configuration registers of several functions, one 32-bit word per clock cycle, interleaved in time. A 2-bit function tag comes with every word. The block finds the group of slots that belongs to physical function 0 and copies its eight words into a shadow register file. From one of those words it decodes two size fields, the maximum payload size and the maximum read request size, into byte counts that user logic can use directly.

The bus repeats on a fixed 48-cycle frame:

- The first eight cycles carry data.
- The remaining 40 cycles carry nothing the block needs.

The block aligns to the frame when the function tag first becomes zero. This happens either right after reset or after a non-zero tag. From that point a free-running slot counter tracks the frame, and the block checks that the tag stays zero for the whole data group. The shadow words, the decoded sizes and the error flag change only when a complete group has been collected. A valid flag reports that the captured contents are current and that lock is held.

Top module: `cfg_tdm_capture`

## Requirements
- R1: While reset is high, and in the cycle after it, `cfg_valid`, `size_err`, `mps_bytes`, `mrrs_bytes` and every shadow word read zero. Reset is synchronous and active high.
- R2: When not locked, a cycle with `fn_tag` = 2'b00 becomes slot 0 of a frame if the previous cycle had a non-zero tag or was in reset. Slot n of that frame is the n-th cycle after slot 0, counted modulo 48.
- R3: After a complete group, shadow word i (bits [32*i+31:32*i] of `shadow_words`) equals the `cfg_word` value of slot i, for i = 0 to 7.
- R4: While locked, slots 8 to 47 are ignored, whatever their tag or data. A zero tag there does not realign the frame, and the next group begins exactly 48 cycles after the previous slot 0.
- R5: The shadow words, the decoded sizes and `size_err` all change together, on the clock edge that samples slot 7. `cfg_valid` rises on that same edge. Before that edge, none of these outputs shows any part of the new group.
- R6: A non-zero tag in any of slots 0 to 7 while locked drops the lock, and `cfg_valid` falls on that edge. The partial group is discarded: the shadow words and the decoded sizes keep their earlier values.
- R7: `mps_bytes` is 128 shifted left by the 3-bit code in bits [2:0] of shadow word 0. The codes map as 0→128, 1→256, 2→512, 3→1024, 4→2048 and 5→4096.
- R8: `mrrs_bytes` decodes bits [5:3] of shadow word 0 with the same mapping as R7.
- R9: Codes 6 and 7 are reserved. A reserved code leaves that field's byte count at its previous value, and `size_err` is 1 after that group. `size_err` returns to 0 after the next group in which both codes are legal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fn_tag | input | 2 | Function tag of the current bus word |
| cfg_word | input | 32 | Configuration bus data word |
| shadow_words | output | 256 | Eight captured words, word i at bits [32*i+31:32*i] |
| mps_bytes | output | 13 | Decoded maximum payload size in bytes |
| mrrs_bytes | output | 13 | Decoded maximum read request size in bytes |
| cfg_valid | output | 1 | Captured contents current and lock held |
| size_err | output | 1 | Last committed group held a reserved size code |

## Verification
Two events are both decided at slot 7: committing the finished group and checking lock on the last data slot. The bench places a non-zero tag exactly on slot 7, and on slot 0, of frames whose new words and size codes differ from the stored ones. A correct result is that `cfg_valid` drops and the shadow words and byte counts keep the earlier frame's values. A second overlap is a reserved-code hold landing on the same commit edge as a legal update of the other field. The bench judges it by requiring one byte count to stay put, the other to move, and `size_err` to rise, all on the same commit edge.

// File: rtl/cfg_tdm_pkg.sv
package cfg_tdm_pkg;
  localparam int CODE_W = 3;

  // Codes 6 and 7 have no size assigned.
  function automatic logic code_reserved(input logic [CODE_W-1:0] code);
    return code > 3'd5;
  endfunction
endpackage

// File: rtl/cfg_tdm_framer.sv
module cfg_tdm_framer #(
  parameter int FRAME_LEN  = 48,
  parameter int DATA_SLOTS = 8,
  localparam int SLOT_W = $clog2(FRAME_LEN),
  localparam int IDX_W  = $clog2(DATA_SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tag_zero,
  output logic             locked,
  output logic             take,
  output logic             commit,
  output logic             drop,
  output logic [IDX_W-1:0] data_idx
);
  logic              armed_q;
  logic              locked_q;
  logic [SLOT_W-1:0] slot_q;
  logic              align;
  logic              in_data;

  always_comb begin
    align    = !locked_q && tag_zero && armed_q;
    in_data  = locked_q && (slot_q < SLOT_W'(DATA_SLOTS));
    take     = align || (in_data && tag_zero);
    drop     = in_data && !tag_zero;
    data_idx = align ? '0 : slot_q[IDX_W-1:0];
    commit   = take && (data_idx == IDX_W'(DATA_SLOTS - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q  <= 1'b1;
      locked_q <= 1'b0;
      slot_q   <= '0;
    end else begin
      armed_q <= !tag_zero;
      if (align) begin
        locked_q <= 1'b1;
        slot_q   <= SLOT_W'(1);
      end else if (drop) begin
        locked_q <= 1'b0;
        slot_q   <= '0;
      end else if (locked_q) begin
        slot_q <= (slot_q == SLOT_W'(FRAME_LEN - 1)) ? '0 : slot_q + SLOT_W'(1);
      end
    end
  end

  assign locked = locked_q;

  p_slot_bound_r4: assert property (@(posedge clk) disable iff (rst)
    locked_q |-> (slot_q < SLOT_W'(FRAME_LEN)));

  p_align_starts_r2: assert property (@(posedge clk) disable iff (rst)
    align |=> (locked_q && slot_q == SLOT_W'(1)));

  p_gap_keeps_lock_r4: assert property (@(posedge clk) disable iff (rst)
    (locked_q && slot_q >= SLOT_W'(DATA_SLOTS)) |=> locked_q);
endmodule

// File: rtl/cfg_tdm_shadow.sv
module cfg_tdm_shadow #(
  parameter int WORDS      = 8,
  parameter int DW         = 32,
  parameter int FIELD_SLOT = 0,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                take,
  input  logic                commit,
  input  logic [IDX_W-1:0]    idx,
  input  logic [DW-1:0]       word,
  output logic [WORDS*DW-1:0] shadow_flat,
  output logic [DW-1:0]       field_word
);
  logic [DW-1:0] stage [WORDS];

  // Staging store: written one word per data slot, no reset (RAM-friendly).
  always_ff @(posedge clk) begin
    if (take) stage[idx] <= word;
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_shadow
    logic [DW-1:0] sh_q;
    always_ff @(posedge clk) begin
      if (rst)         sh_q <= '0;
      else if (commit) sh_q <= (idx == IDX_W'(g)) ? word : stage[g];
    end
    assign shadow_flat[g*DW +: DW] = sh_q;
  end

  assign field_word = (idx == IDX_W'(FIELD_SLOT)) ? word : stage[FIELD_SLOT];

  p_shadow_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(shadow_flat));
endmodule

// File: rtl/cfg_size_decode.sv
module cfg_size_decode
  import cfg_tdm_pkg::*;
#(
  parameter int OUT_W = 13,
  parameter int BASE  = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CODE_W-1:0] code,
  output logic [OUT_W-1:0]  bytes,
  output logic              reserved
);
  assign reserved = code_reserved(code);

  always_ff @(posedge clk) begin
    if (rst)                       bytes <= '0;
    else if (load && !reserved)    bytes <= OUT_W'(BASE) << code;
  end

  p_hold_reserved_r9: assert property (@(posedge clk) disable iff (rst)
    (load && reserved) |=> $stable(bytes));

  p_power_of_two_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bytes));
endmodule

// File: rtl/cfg_tdm_capture.sv
module cfg_tdm_capture
  import cfg_tdm_pkg::*;
#(
  parameter int DW         = 32,
  parameter int WORDS      = 8,
  parameter int FRAME_LEN  = 48,
  parameter int FIELD_SLOT = 0,
  parameter int MPS_LSB    = 0,
  parameter int MRRS_LSB   = 3,
  parameter int BYTES_W    = 13
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          fn_tag,
  input  logic [DW-1:0]       cfg_word,
  output logic [WORDS*DW-1:0] shadow_words,
  output logic [BYTES_W-1:0]  mps_bytes,
  output logic [BYTES_W-1:0]  mrrs_bytes,
  output logic                cfg_valid,
  output logic                size_err
);
  localparam int IDX_W = $clog2(WORDS);

  logic             locked, take, commit, drop;
  logic [IDX_W-1:0] data_idx;
  logic [DW-1:0]    field_word;
  logic             mps_res, mrrs_res;

  cfg_tdm_framer #(.FRAME_LEN(FRAME_LEN), .DATA_SLOTS(WORDS)) u_framer (
    .clk(clk), .rst(rst), .tag_zero(fn_tag == 2'b00),
    .locked(locked), .take(take), .commit(commit), .drop(drop),
    .data_idx(data_idx)
  );

  cfg_tdm_shadow #(.WORDS(WORDS), .DW(DW), .FIELD_SLOT(FIELD_SLOT)) u_shadow (
    .clk(clk), .rst(rst), .take(take), .commit(commit), .idx(data_idx),
    .word(cfg_word), .shadow_flat(shadow_words), .field_word(field_word)
  );

  cfg_size_decode #(.OUT_W(BYTES_W)) u_mps (
    .clk(clk), .rst(rst), .load(commit),
    .code(field_word[MPS_LSB +: CODE_W]), .bytes(mps_bytes), .reserved(mps_res)
  );

  cfg_size_decode #(.OUT_W(BYTES_W)) u_mrrs (
    .clk(clk), .rst(rst), .load(commit),
    .code(field_word[MRRS_LSB +: CODE_W]), .bytes(mrrs_bytes), .reserved(mrrs_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_valid <= 1'b0;
      size_err  <= 1'b0;
    end else begin
      if (drop)        cfg_valid <= 1'b0;
      else if (commit) cfg_valid <= 1'b1;
      if (commit)      size_err  <= mps_res || mrrs_res;
    end
  end

  p_valid_locked_r6: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |-> locked);

  p_valid_after_commit_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_valid) |-> $past(commit));

  p_drop_clears_valid_r6: assert property (@(posedge clk) disable iff (rst)
    drop |=> !cfg_valid);
endmodule

// File: tb/sim_cfg_tdm_capture.sv
module sim_cfg_tdm_capture;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   fn_tag = 2'b11;
  logic [31:0]  cfg_word = '0;
  logic [255:0] shadow_words;
  logic [12:0]  mps_bytes, mrrs_bytes;
  logic         cfg_valid, size_err;

  cfg_tdm_capture u0 (
    .clk(clk), .rst(rst), .fn_tag(fn_tag), .cfg_word(cfg_word),
    .shadow_words(shadow_words), .mps_bytes(mps_bytes), .mrrs_bytes(mrrs_bytes),
    .cfg_valid(cfg_valid), .size_err(size_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit release_pending = 0;

  logic [31:0] stim_w [8];
  logic [31:0] exp_sh [8];
  logic [12:0] exp_mps = '0, exp_mrrs = '0;
  logic        exp_err = 0, exp_valid = 0;

  function automatic logic [12:0] size_of(input logic [2:0] c, input logic [12:0] prev);
    return (c <= 3'd5) ? (13'd128 << c) : prev;
  endfunction

  task automatic check_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_outputs(input string req);
    for (int i = 0; i < 8; i++) check_eq({req, " shadow word"}, 64'(shadow_words[i*32 +: 32]), 64'(exp_sh[i]));
    check_eq({req, " mps"},   64'(mps_bytes),  64'(exp_mps));
    check_eq({req, " mrrs"},  64'(mrrs_bytes), 64'(exp_mrrs));
    check_eq({req, " err"},   64'(size_err),   64'(exp_err));
    check_eq({req, " valid"}, 64'(cfg_valid),  64'(exp_valid));
  endtask

  // bad_slot < 8 puts a non-zero tag there; the rest of that frame keeps a non-zero tag.
  task automatic run_frame(input int bad_slot, input bit alt_gap, input string req);
    bit broken = 0;
    for (int s = 0; s < 48; s++) begin
      @(negedge clk);
      if (release_pending) begin rst = 1'b0; release_pending = 0; end
      if (s == 7 && !broken) check_outputs("R5 before commit");
      if (s == bad_slot) broken = 1;
      if (s < 8) begin
        fn_tag   = broken ? 2'(1 + $urandom % 3) : 2'b00;
        cfg_word = broken ? $urandom : stim_w[s];
      end else begin
        fn_tag   = broken ? 2'b01 : (alt_gap ? 2'(s % 2) : 2'($urandom % 4));
        cfg_word = $urandom;
      end
    end
    if (broken) begin
      exp_valid = 0;
    end else begin
      for (int i = 0; i < 8; i++) exp_sh[i] = stim_w[i];
      exp_mps   = size_of(stim_w[0][2:0], exp_mps);
      exp_mrrs  = size_of(stim_w[0][5:3], exp_mrrs);
      exp_err   = (stim_w[0][2:0] > 3'd5) || (stim_w[0][5:3] > 3'd5);
      exp_valid = 1;
    end
    check_outputs(req);
  endtask

  task automatic fill(input logic [2:0] mps_c, input logic [2:0] mrrs_c);
    for (int i = 0; i < 8; i++) stim_w[i] = $urandom;
    stim_w[0][2:0] = mps_c;
    stim_w[0][5:3] = mrrs_c;
  endtask

  initial begin
    void'($urandom(32'h5EED_0C0F));
    for (int i = 0; i < 8; i++) exp_sh[i] = '0;
    repeat (4) @(negedge clk);
    check_outputs("R1 in reset");
    release_pending = 1;
    // R2: frame starts on the first cycle out of reset with a zero tag
    fill(3'd0, 3'd0); run_frame(99, 0, "R2 R3 R7 R8 first frame");
    fill(3'd1, 3'd2); run_frame(99, 1, "R4 alternating gap tags");
    fill(3'd3, 3'd5); run_frame(99, 0, "R7 R8 codes 3 and 5");
    fill(3'd2, 3'd4); run_frame(99, 0, "R7 R8 codes 2 and 4");
    fill(3'd6, 3'd1); run_frame(99, 0, "R9 mps reserved hold");
    fill(3'd5, 3'd7); run_frame(99, 0, "R9 mrrs reserved hold");
    fill(3'd4, 3'd3); run_frame(99, 0, "R9 error clears");
    fill(3'd0, 3'd5); run_frame(7,  0, "R6 drop at slot 7");
    fill(3'd1, 3'd1); run_frame(99, 0, "R2 realign after drop");
    fill(3'd5, 3'd0); run_frame(0,  0, "R6 drop at slot 0");
    fill(3'd2, 3'd3); run_frame(3,  0, "R6 drop at slot 3");
    fill(3'd7, 3'd6); run_frame(99, 0, "R9 both reserved");
    for (int n = 0; n < 24; n++) begin
      fill(3'($urandom % 8), 3'($urandom % 8));
      run_frame(($urandom % 5 == 0) ? int'($urandom % 8) : 99, n[0], "R3 R4 R6 R9 random frame");
    end
    // R1: reset again mid-operation
    @(negedge clk); rst = 1'b1; fn_tag = 2'b00;
    @(negedge clk);
    for (int i = 0; i < 8; i++) exp_sh[i] = '0;
    exp_mps = '0; exp_mrrs = '0; exp_err = 0; exp_valid = 0;
    check_outputs("R1 reset after traffic");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule